// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the status and control register of one USB host root port, reached through a plain 32-bit register write port and a read port that always shows the current value. The port hardware supplies several inputs: connection state, overcurrent state, a fault that drops the port, the levels of the two data lines and the speed of the attached device. The register samples these inputs. For the connection, enable and overcurrent states it records every change in a sticky flag that software clears by writing 1. While any flag is set, an interrupt output is high.

Software drives port power, port reset, suspend, resume and a test-mode field through the same word. The enable state cannot be set by software. It becomes 1 when software ends a port reset on a connected port. It becomes 0 when software writes 1 to the enable bit, when a port reset starts, on a disconnect, or on a hardware fault. The control outputs leave the block straight from the stored bits. Generating the reset signalling and its timing is the job of the logic outside this block.

Top module: `rportcsr`

## Requirements
- R1: Bit 0 (connected) shows the value of `hw_connected` one clock after it is sampled, and writes never change it.
- R2: Bit 4 (overcurrent) shows the value of `hw_overcurrent` one clock after it is sampled, and writes never change it.
- R3: Change flags sit at bit 1 (for bit 0), bit 3 (for bit 2) and bit 4's partner bit 5. Each flag becomes 1 in the same clock in which its status bit takes a new value, and it stays 1 until it is cleared.
- R4: A write with 1 in bit 1, 3 or 5 clears that flag. A write with 0 in one of those positions leaves that flag unchanged.
- R5: Bit 2 (enabled) becomes 1 in the clock after a write takes bit 8 (port reset) from 1 to 0 while the port is connected. It becomes 0 when bit 8 goes from 0 to 1, when `hw_connected` is low, or when `hw_fault` is high.
- R6: A write with 1 in bit 2 makes the port disabled. No write can make it enabled.
- R7: `port_irq` is high exactly while at least one of bits 1, 3 and 5 reads 1.
- R8: Bits 11:10 show the sampled `hw_line` and are read-only. Bits 18:17 show the sampled `hw_speed` (00 high, 01 full, 10 low) while bit 0 is 1, and read 00 while bit 0 is 0.
- R9: If a status change and a write-1 clear hit the same flag in the same clock, the flag stays set.
- R10: Bit 9 and bits 31:19 always read 0, whatever is written to them.
- R11: Bits 6 (resume), 7 (suspend), 8 (port reset), 12 (power) and 16:13 (test mode) read back the last value written to them and drive `port_resume`, `port_suspend`, `port_reset`, `port_power` and `port_test`.
- R12: After reset, with all hardware inputs low, the register reads 0 and `port_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Current register value |
| hw_connected | input | 1 | A device is attached |
| hw_overcurrent | input | 1 | Overcurrent condition on the port |
| hw_fault | input | 1 | Hardware condition that disables the port |
| hw_line | input | 2 | Data line levels |
| hw_speed | input | 2 | Speed of the attached device |
| port_irq | output | 1 | Port interrupt request |
| port_power | output | 1 | Port power control |
| port_reset | output | 1 | Port reset control |
| port_suspend | output | 1 | Suspend request |
| port_resume | output | 1 | Resume signalling request |
| port_test | output | 4 | Test-mode field |

## Verification
The assertions check on every cycle that each flag is set when its status changes, that the set beats a concurrent clear, and that a clear with no change empties the flag. They also check that the enable bit rises only after the reset bit falls, that a disable write always takes effect, that the connected bit follows its input, that the speed and reserved fields read as required, and that a set flag drives the interrupt. Only the bench scenarios show the full picture: the exact word read back after each write sequence, that a written 0 leaves a flag alone, that the flags are independent of each other, and that a full port reset followed by a disconnect moves through the expected encodings.

// File: rtl/rportcsr_pkg.sv
package rportcsr_pkg;

   // Bit positions of the port word; software decodes these directly.
   localparam int unsigned CONN_BIT    = 0;
   localparam int unsigned CONN_CHG    = 1;
   localparam int unsigned EN_BIT      = 2;
   localparam int unsigned EN_CHG      = 3;
   localparam int unsigned OC_BIT      = 4;
   localparam int unsigned OC_CHG      = 5;
   localparam int unsigned RESUME_BIT  = 6;
   localparam int unsigned SUSPEND_BIT = 7;
   localparam int unsigned PRST_BIT    = 8;
   localparam int unsigned LINE_LSB    = 10;
   localparam int unsigned LINE_W      = 2;
   localparam int unsigned POWER_BIT   = 12;
   localparam int unsigned TEST_LSB    = 13;
   localparam int unsigned TEST_W      = 4;
   localparam int unsigned SPEED_LSB   = TEST_LSB + TEST_W;
   localparam int unsigned SPEED_W     = 2;
   localparam int unsigned USED_W      = SPEED_LSB + SPEED_W;

   // Number of status bits that carry a sticky change flag.
   localparam int unsigned N_TRACKED   = 3;

   typedef enum logic [SPEED_W-1:0] {
      SPD_HIGH = 2'b00,
      SPD_FULL = 2'b01,
      SPD_LOW  = 2'b10,
      SPD_RSVD = 2'b11
   } port_speed_e;

   typedef struct packed {
      logic [TEST_W-1:0] test;
      logic              power;
      logic              prst;
      logic              suspend;
      logic              resume;
   } port_ctl_t;

endpackage

// File: rtl/rportcsr_chg.sv
module rportcsr_chg (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_d,
   input  logic clr,
   output logic stat_q,
   output logic flag_q
);

   logic changed;
   assign changed = stat_d ^ stat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         stat_q <= stat_d;
         flag_q <= (flag_q & ~clr) | changed;
      end
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_d != stat_q) |=> flag_q);

   // R4
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && stat_d == stat_q) |=> !flag_q);

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && flag_q) |=> flag_q);

endmodule

// File: rtl/rportcsr_ctl.sv
module rportcsr_ctl
   import rportcsr_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output port_ctl_t        ctl_q,
   output logic             prst_d
);

   port_ctl_t ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (wr_en) begin
         ctl_d.resume  = wr_data[RESUME_BIT];
         ctl_d.suspend = wr_data[SUSPEND_BIT];
         ctl_d.prst    = wr_data[PRST_BIT];
         ctl_d.power   = wr_data[POWER_BIT];
         ctl_d.test    = wr_data[TEST_LSB +: TEST_W];
      end
   end

   assign prst_d = ctl_d.prst;

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   // R11
   ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl_q.prst == $past(wr_data[PRST_BIT])));

endmodule

// File: rtl/rportcsr_lsamp.sv
module rportcsr_lsamp
   import rportcsr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LINE_W-1:0]  line_in,
   input  logic [SPEED_W-1:0] speed_in,
   output logic [LINE_W-1:0]  line_q,
   output port_speed_e        speed_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         speed_q <= SPD_HIGH;
      end else begin
         line_q  <= line_in;
         speed_q <= port_speed_e'(speed_in);
      end
   end

endmodule

// File: rtl/rportcsr.sv
module rportcsr
   import rportcsr_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             hw_connected,
   input  logic             hw_overcurrent,
   input  logic             hw_fault,
   input  logic [1:0]       hw_line,
   input  logic [1:0]       hw_speed,
   output logic             port_irq,
   output logic             port_power,
   output logic             port_reset,
   output logic             port_suspend,
   output logic             port_resume,
   output logic [3:0]       port_test
);

   localparam int unsigned RSVD_W = REG_W - USED_W;

   generate
      if (REG_W < USED_W) begin : g_bad_width
         $error("rportcsr: REG_W too small for the port word");
      end
      if (TEST_W != 4 || LINE_W != 2 || SPEED_W != 2) begin : g_bad_fields
         $error("rportcsr: field widths do not match the port list");
      end
   endgenerate

   // Software control storage
   port_ctl_t ctl_q;
   logic      prst_d;

   rportcsr_ctl #(.REG_W(REG_W)) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctl_q   (ctl_q),
      .prst_d  (prst_d)
   );

   // Line and speed sampling
   logic [LINE_W-1:0] line_q;
   port_speed_e       speed_q;

   rportcsr_lsamp lsamp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (hw_line),
      .speed_in (hw_speed),
      .line_q   (line_q),
      .speed_q  (speed_q)
   );

   // Tracked status bits: index 0 connected, 1 enabled, 2 overcurrent
   logic [N_TRACKED-1:0] stat_d, stat_q, flag_q, flag_clr;
   logic                 conn_q, en_q, oc_q;
   logic                 rst_leave, rst_enter, dis_write, en_d;

   assign conn_q = stat_q[0];
   assign en_q   = stat_q[1];
   assign oc_q   = stat_q[2];

   assign rst_leave = ctl_q.prst & ~prst_d;
   assign rst_enter = ~ctl_q.prst & prst_d;
   assign dis_write = wr_en & wr_data[EN_BIT];

   always_comb begin
      en_d = en_q | (rst_leave & conn_q);
      if (dis_write || rst_enter || hw_fault || !hw_connected) en_d = 1'b0;
   end

   assign stat_d = {hw_overcurrent, en_d, hw_connected};

   generate
      for (genvar gi = 0; gi < N_TRACKED; gi++) begin : g_track
         localparam int unsigned FLAG_POS = 2 * gi + 1;
         assign flag_clr[gi] = wr_en & wr_data[FLAG_POS];
         rportcsr_chg chg_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .stat_d (stat_d[gi]),
            .clr    (flag_clr[gi]),
            .stat_q (stat_q[gi]),
            .flag_q (flag_q[gi])
         );
      end
   endgenerate

   // Read word assembly
   always_comb begin
      rd_data                            = '0;
      rd_data[CONN_BIT]                  = conn_q;
      rd_data[CONN_CHG]                  = flag_q[0];
      rd_data[EN_BIT]                    = en_q;
      rd_data[EN_CHG]                    = flag_q[1];
      rd_data[OC_BIT]                    = oc_q;
      rd_data[OC_CHG]                    = flag_q[2];
      rd_data[RESUME_BIT]                = ctl_q.resume;
      rd_data[SUSPEND_BIT]               = ctl_q.suspend;
      rd_data[PRST_BIT]                  = ctl_q.prst;
      rd_data[LINE_LSB +: LINE_W]        = line_q;
      rd_data[POWER_BIT]                 = ctl_q.power;
      rd_data[TEST_LSB +: TEST_W]        = ctl_q.test;
      rd_data[SPEED_LSB +: SPEED_W]      = conn_q ? speed_q : SPD_HIGH;
   end

   assign port_irq     = |flag_q;
   assign port_power   = ctl_q.power;
   assign port_reset   = ctl_q.prst;
   assign port_suspend = ctl_q.suspend;
   assign port_resume  = ctl_q.resume;
   assign port_test    = ctl_q.test;

   // Write bits with no writable storage behind them
   logic unused_wr;
   generate
      if (RSVD_W > 0) begin : g_unused_hi
         assign unused_wr = ^{wr_data[REG_W-1:USED_W], wr_data[SPEED_LSB +: SPEED_W],
                              wr_data[LINE_LSB +: LINE_W], wr_data[9],
                              wr_data[OC_BIT], wr_data[CONN_BIT]};
      end else begin : g_unused_lo
         assign unused_wr = ^{wr_data[SPEED_LSB +: SPEED_W], wr_data[LINE_LSB +: LINE_W],
                              wr_data[9], wr_data[OC_BIT], wr_data[CONN_BIT]};
      end
   endgenerate

   // R1
   conn_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rd_data[CONN_BIT] == $past(hw_connected)));

   // R2
   oc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rd_data[OC_BIT] == $past(hw_overcurrent)));

   // R5
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> ($past(ctl_q.prst) && !ctl_q.prst));

   // R6
   dis_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_write |=> !rd_data[EN_BIT]);

   // R7
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[CONN_CHG] || rd_data[EN_CHG] || rd_data[OC_CHG]) |-> port_irq);

   // R8
   speed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[CONN_BIT] |-> (rd_data[SPEED_LSB +: SPEED_W] == 2'b00));

   // R10
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[9] && (RSVD_W == 0 || rd_data >> USED_W == '0));

endmodule

// File: tb/rportcsr_tb_top.sv
module rportcsr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        hw_connected = 1'b0;
   logic        hw_overcurrent = 1'b0;
   logic        hw_fault = 1'b0;
   logic [1:0]  hw_line = 2'b00;
   logic [1:0]  hw_speed = 2'b00;
   logic        port_irq, port_power, port_reset, port_suspend, port_resume;
   logic [3:0]  port_test;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rportcsr #(.REG_W(32)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_data        (wr_data),
      .rd_data        (rd_data),
      .hw_connected   (hw_connected),
      .hw_overcurrent (hw_overcurrent),
      .hw_fault       (hw_fault),
      .hw_line        (hw_line),
      .hw_speed       (hw_speed),
      .port_irq       (port_irq),
      .port_power     (port_power),
      .port_reset     (port_reset),
      .port_suspend   (port_suspend),
      .port_resume    (port_resume),
      .port_test      (port_test)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Write at a falling edge, return at the next falling edge.
   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk("R12 word", rd_data, 32'h0);
      chk("R12 irq", {31'b0, port_irq}, 32'h0);
   endtask

   task automatic t_connect();
      hw_connected = 1'b1; hw_speed = 2'b01; hw_line = 2'b10;
      step();
      chk("R1 R3 R8 connect word", rd_data, 32'h0002_0803);
      chk("R7 irq on connect", {31'b0, port_irq}, 32'h1);
   endtask

   task automatic t_w1c();
      wr(32'h0000_0001);
      chk("R4 R1 write 0 keeps flag, bit0 unwritable", rd_data, 32'h0002_0803);
      wr(32'h0000_0002);
      chk("R4 write 1 clears flag", rd_data, 32'h0002_0801);
      chk("R7 irq low", {31'b0, port_irq}, 32'h0);
   endtask

   task automatic t_port_reset();
      wr(32'h0000_1100);
      chk("R11 reset and power stored", rd_data, 32'h0002_1901);
      chk("R11 port_reset pin", {30'b0, port_reset, port_power}, 32'h3);
      wr(32'h0000_1000);
      chk("R5 enabled after reset ends", rd_data, 32'h0002_180D);
      wr(32'h0000_1008);
      chk("R4 enable flag cleared", rd_data, 32'h0002_1805);
   endtask

   task automatic t_disable();
      wr(32'h0000_1004);
      chk("R6 write 1 disables", rd_data, 32'h0002_1809);
      wr(32'h0000_1008);
      chk("R6 write cannot enable", rd_data, 32'h0002_1801);
   endtask

   task automatic t_overcurrent();
      hw_overcurrent = 1'b1;
      step();
      chk("R2 R3 overcurrent", rd_data, 32'h0002_1831);
      @(negedge clk);
      hw_overcurrent = 1'b0;
      wr_en = 1'b1; wr_data = 32'h0000_1020;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R9 set beats clear", rd_data, 32'h0002_1821);
      wr(32'h0000_1020);
      chk("R4 overcurrent flag cleared", rd_data, 32'h0002_1801);
   endtask

   task automatic t_reserved();
      wr(32'hFFFF_FFFF);
      chk("R10 reserved bits zero", rd_data & 32'hFFF8_0200, 32'h0);
      chk("R10 R11 all-ones word", rd_data, 32'h0003_F9C1);
      chk("R11 control pins", {24'b0, port_test, port_resume, port_suspend, port_reset, port_power},
          32'h0000_00FF);
      wr(32'h0000_0000);
      chk("R5 R11 reset released", rd_data, 32'h0002_080D);
      wr(32'h0000_0008);
      chk("R4 clear", rd_data, 32'h0002_0805);
   endtask

   task automatic t_fault();
      hw_fault = 1'b1;
      step();
      hw_fault = 1'b0;
      chk("R5 fault disables", rd_data, 32'h0002_0809);
      wr(32'h0000_0008);
      chk("R4 clear after fault", rd_data, 32'h0002_0801);
   endtask

   task automatic t_reset_while_enabled();
      wr(32'h0000_0100);
      wr(32'h0000_0000);
      chk("R5 enable again", rd_data, 32'h0002_080D);
      wr(32'h0000_0008);
      wr(32'h0000_0100);
      chk("R5 reset start disables", rd_data, 32'h0002_0909);
      wr(32'h0000_0108);
      chk("R4 clear during reset", rd_data, 32'h0002_0901);
      wr(32'h0000_0000);
      chk("R5 reset end enables", rd_data, 32'h0002_080D);
      wr(32'h0000_0008);
      chk("R4 clear", rd_data, 32'h0002_0805);
   endtask

   task automatic t_disconnect();
      hw_connected = 1'b0; hw_line = 2'b00;
      step();
      chk("R1 R5 R8 disconnect", rd_data, 32'h0000_000A);
      wr(32'h0000_000A);
      chk("R4 both cleared", rd_data, 32'h0);
      chk("R7 irq low", {31'b0, port_irq}, 32'h0);
      hw_connected = 1'b1; hw_speed = 2'b10;
      step();
      chk("R8 low speed", rd_data, 32'h0004_0003);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset_state();
      t_connect();
      t_w1c();
      t_port_reset();
      t_disable();
      t_overcurrent();
      t_reserved();
      t_fault();
      t_reset_while_enabled();
      t_disconnect();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule